// File: doc/BRIEF.md
# Chained Descriptor 2D DMA Channel

This block is a single DMA channel that walks a linked list of control blocks held in memory. A start pulse hands it the address of the first block. It reads the six words of that block and then moves 32-bit words from a source address to a destination address. The move is either one flat run or a set of rows that are separated by signed strides. When the block is finished the channel raises its completion flag, and it may also raise its interrupt. It then follows the pointer to the next block. The walk stops at a null pointer, or when the channel enable is low at a block boundary.

All memory traffic goes through one word-wide master port. That port has a valid/ready request and a separate read-data-valid return, and it allows only one request in flight at a time. Each side of the transfer can advance its address or hold it fixed. Each side can also be switched off: a source that is switched off supplies zero words, and a destination that is switched off receives no writes. The remaining length is written back after every beat and is visible on an output.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, active, paused, end and irq are all 0, and no memory request is raised.
- R2: For every control block at address P, the channel first issues six reads at P, P+4, P+8, P+12, P+16 and P+20. These words are, in that order: info, source address, destination address, length, stride and next pointer.
- R3: In flat mode (info bit 1 clear), the channel performs ceil(length/4) beats, so a length that is not a multiple of 4 rounds up. Each beat reads one word at the source and then writes that word to the destination. The source address advances by 4 after each beat when info bit 8 is set; the destination address advances by 4 when info bit 4 is set. An address whose bit is clear stays fixed.
- R4: With info bit 11 set, no source read is issued, and every destination write carries the data 0.
- R5: With info bit 7 set, no destination write is issued. Source reads still take place.
- R6: In row mode (info bit 1 set), the row count is length[29:16] and the bytes per row is length[15:0]. Between rows only, never after the last row, the signed value stride[15:0] is added to the source address and the signed value stride[31:16] is added to the destination address.
- R7: In row mode with a row count of 0, the channel issues no beats, but the block still completes and the walk follows the next pointer.
- R8: After each beat, len_o shows the remaining byte count. In row mode it shows {rows_remaining in [29:16], bytes_remaining in [15:0]}, where rows_remaining counts the current row. After a flat block it reads 0; after a row-mode block it reads 0x00010000.
- R9: Completing a block sets end_o. If info bit 0 is set, completing the block also sets irq_o. A start clears both flags.
- R10: The walk ends when the next pointer is 0, or when chan_en_i is low at a block boundary. At that point active_o falls and paused_o rises. A start with a null address ends at once, with no memory traffic.
- R11: At most one memory request is outstanding. A request is held, with address, direction and data stable, until it is accepted. No new request is raised while read data is awaited.
- R12: A start pulse that arrives while the channel is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a descriptor walk |
| chan_en_i | input | 1 | Channel enable, sampled at each block boundary |
| cb_addr_i | input | 32 | Byte address of the first control block |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write when 1 |
| mem_addr_o | output | 32 | Request byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rvalid_i | input | 1 | Read data is valid |
| mem_rdata_i | input | 32 | Read data |
| active_o | output | 1 | Channel is walking the chain |
| paused_o | output | 1 | Channel has stopped after a walk |
| end_o | output | 1 | At least one block has completed since the last start |
| irq_o | output | 1 | Interrupt flag and line |
| len_o | output | 32 | Remaining-length register |

## Verification
Four properties are checked on every cycle:
- the request handshake holds its request stable until it is accepted, and raises no request while read data is awaited;
- active and paused are never high together;
- the channel raises no request while inactive;
- irq never rises without end.

Only the bench scenarios show the rest. That covers the address sequences for flat and row transfers, the rounding of the beat count, zero data from a switched-off source, dropped writes to a switched-off destination, stride placement between rows, the written-back length, chain following, the stop on enable, and a start that is ignored while active. The bench checks these by comparing every accepted memory request against a queue of expected transactions, built from the descriptor contents.

// File: rtl/dma_chain_pkg.sv
`timescale 1ns/1ps
package dma_chain_pkg;
   localparam int CB_WORDS    = 6;
   localparam int IB_IRQ      = 0;
   localparam int IB_TWO_D    = 1;
   localparam int IB_DST_INC  = 4;
   localparam int IB_DST_SKIP = 7;
   localparam int IB_SRC_INC  = 8;
   localparam int IB_SRC_SKIP = 11;

   typedef enum logic [3:0] {
      S_IDLE, S_CHK, S_FGO, S_FWAIT, S_SETUP, S_BEGIN,
      S_RGO, S_RWAIT, S_WGO, S_WWAIT, S_BEAT, S_ROW, S_DONE
   } eng_state_t;

   typedef struct packed {
      logic irq_en;
      logic two_d;
      logic src_inc;
      logic dst_inc;
      logic src_skip;
      logic dst_skip;
   } cb_flags_t;
endpackage

// File: rtl/dma_cb_decode.sv
`timescale 1ns/1ps
module dma_cb_decode
   import dma_chain_pkg::*;
#(
   parameter int DW       = 32,
   parameter int ROW_W    = 14,
   parameter int XB_W     = 16,
   parameter bit ROUND_UP = 1'b1,
   localparam int WCNT_W  = DW - 1,
   localparam int STR_W   = DW / 2
) (
   input  logic [DW-1:0]     info_i,
   input  logic [DW-1:0]     len_i,
   input  logic [DW-1:0]     stride_i,
   output cb_flags_t         flags_o,
   output logic [ROW_W-1:0]  rows_o,
   output logic [DW-1:0]     row_bytes_o,
   output logic [WCNT_W-1:0] row_words_o,
   output logic [DW-1:0]     src_step_o,
   output logic [DW-1:0]     dst_step_o
);
   logic [DW:0] bytes_ext;
   logic        unused_bits;

   assign flags_o.irq_en   = info_i[IB_IRQ];
   assign flags_o.two_d    = info_i[IB_TWO_D];
   assign flags_o.src_inc  = info_i[IB_SRC_INC];
   assign flags_o.dst_inc  = info_i[IB_DST_INC];
   assign flags_o.src_skip = info_i[IB_SRC_SKIP];
   assign flags_o.dst_skip = info_i[IB_DST_SKIP];

   always_comb begin
      if (info_i[IB_TWO_D]) begin
         rows_o      = len_i[XB_W+ROW_W-1:XB_W];
         row_bytes_o = DW'(len_i[XB_W-1:0]);
         src_step_o  = {{(DW-STR_W){stride_i[STR_W-1]}}, stride_i[STR_W-1:0]};
         dst_step_o  = {{(DW-STR_W){stride_i[DW-1]}}, stride_i[DW-1:STR_W]};
      end else begin
         rows_o      = ROW_W'(1);
         row_bytes_o = len_i;
         src_step_o  = '0;
         dst_step_o  = '0;
      end
   end

   generate
      if (ROUND_UP) begin : g_ceil
         assign bytes_ext = {1'b0, row_bytes_o} + (DW+1)'(3);
      end else begin : g_floor
         assign bytes_ext = {1'b0, row_bytes_o};
      end
   endgenerate
   assign row_words_o = bytes_ext[DW:2];

   assign unused_bits = ^{info_i[DW-1:IB_SRC_SKIP+1], info_i[IB_SRC_INC-1+2:IB_SRC_INC+1],
                          info_i[IB_DST_INC-1:IB_TWO_D+1], info_i[IB_DST_SKIP-1:IB_DST_INC+1],
                          len_i[DW-1:XB_W+ROW_W]};
endmodule

// File: rtl/dma_mem_port.sv
`timescale 1ns/1ps
module dma_mem_port #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue_i,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic          done_o,
   output logic [DW-1:0] rdata_o,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic          mem_ready_i,
   input  logic          mem_rvalid_i,
   input  logic [DW-1:0] mem_rdata_i
);
   typedef enum logic [1:0] {P_IDLE, P_REQ, P_RWAIT} port_state_t;
   port_state_t   pst;
   logic          we_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pst     <= P_IDLE;
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         case (pst)
            P_IDLE: if (issue_i) begin
               pst     <= P_REQ;
               we_q    <= we_i;
               addr_q  <= addr_i;
               wdata_q <= wdata_i;
            end
            P_REQ: if (mem_ready_i) pst <= we_q ? P_IDLE : P_RWAIT;
            P_RWAIT: if (mem_rvalid_i) pst <= P_IDLE;
            default: pst <= P_IDLE;
         endcase
      end
   end

   assign mem_req_o   = (pst == P_REQ);
   assign mem_we_o    = we_q;
   assign mem_addr_o  = addr_q;
   assign mem_wdata_o = wdata_q;
   assign done_o      = ((pst == P_REQ) && mem_ready_i && we_q) ||
                        ((pst == P_RWAIT) && mem_rvalid_i);
   assign rdata_o     = mem_rdata_i;
endmodule

// File: rtl/dma_chain_engine.sv
`timescale 1ns/1ps
module dma_chain_engine
   import dma_chain_pkg::*;
#(
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter int ROW_W    = 14,
   parameter int XB_W     = 16,
   parameter bit ROUND_UP = 1'b1,
   localparam int WCNT_W  = DW - 1,
   localparam int IDX_W   = $clog2(CB_WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          chan_en_i,
   input  logic [AW-1:0] cb_addr_i,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic          mem_ready_i,
   input  logic          mem_rvalid_i,
   input  logic [DW-1:0] mem_rdata_i,
   output logic          active_o,
   output logic          paused_o,
   output logic          end_o,
   output logic          irq_o,
   output logic [DW-1:0] len_o
);
   generate
      if (DW != 32) begin : g_bad_dw
         $error("dma_chain_engine: descriptor words must be 32 bits");
      end
      if (AW != DW) begin : g_bad_aw
         $error("dma_chain_engine: address width must equal word width");
      end
      if (ROW_W + XB_W > DW) begin : g_bad_len
         $error("dma_chain_engine: row and byte fields exceed the length word");
      end
   endgenerate

   eng_state_t        st;
   logic [DW-1:0]     cbw [CB_WORDS];
   logic [IDX_W-1:0]  idx;
   logic [AW-1:0]     cb_ptr, src_a, dst_a;
   logic [ROW_W-1:0]  rows_left;
   logic [WCNT_W-1:0] words_left;
   logic [DW-1:0]     bytes_left, bytes_nx, beat_data, len_q;
   logic              active_q, paused_q, end_q, int_q;

   cb_flags_t         flags;
   logic [ROW_W-1:0]  dec_rows;
   logic [DW-1:0]     dec_bytes, src_step, dst_step;
   logic [WCNT_W-1:0] dec_words;

   logic              p_issue, p_we, p_done;
   logic [AW-1:0]     p_addr;
   logic [DW-1:0]     p_rdata;

   dma_cb_decode #(.DW(DW), .ROW_W(ROW_W), .XB_W(XB_W), .ROUND_UP(ROUND_UP)) u_dec (
      .info_i(cbw[0]), .len_i(cbw[3]), .stride_i(cbw[4]),
      .flags_o(flags), .rows_o(dec_rows), .row_bytes_o(dec_bytes),
      .row_words_o(dec_words), .src_step_o(src_step), .dst_step_o(dst_step)
   );

   always_comb begin
      p_issue = 1'b0;
      p_we    = 1'b0;
      p_addr  = cb_ptr + AW'({idx, 2'b00});
      case (st)
         S_FGO: p_issue = 1'b1;
         S_RGO: begin p_issue = 1'b1; p_addr = src_a; end
         S_WGO: begin p_issue = 1'b1; p_we = 1'b1; p_addr = dst_a; end
         default: ;
      endcase
   end

   dma_mem_port #(.AW(AW), .DW(DW)) u_port (
      .clk(clk), .rst_n(rst_n),
      .issue_i(p_issue), .we_i(p_we), .addr_i(p_addr), .wdata_i(beat_data),
      .done_o(p_done), .rdata_o(p_rdata),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i),
      .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
   );

   assign bytes_nx = (bytes_left > DW'(4)) ? bytes_left - DW'(4) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         idx        <= '0;
         cb_ptr     <= '0;
         src_a      <= '0;
         dst_a      <= '0;
         rows_left  <= '0;
         words_left <= '0;
         bytes_left <= '0;
         beat_data  <= '0;
         len_q      <= '0;
         active_q   <= 1'b0;
         paused_q   <= 1'b0;
         end_q      <= 1'b0;
         int_q      <= 1'b0;
         for (int k = 0; k < CB_WORDS; k++) cbw[k] <= '0;
      end else begin
         case (st)
            S_IDLE: if (start_i) begin
               active_q <= 1'b1;
               paused_q <= 1'b0;
               end_q    <= 1'b0;
               int_q    <= 1'b0;
               cb_ptr   <= cb_addr_i;
               st       <= S_CHK;
            end
            S_CHK: begin
               if ((cb_ptr == '0) || !chan_en_i) begin
                  active_q <= 1'b0;
                  paused_q <= 1'b1;
                  st       <= S_IDLE;
               end else begin
                  idx <= '0;
                  st  <= S_FGO;
               end
            end
            S_FGO: st <= S_FWAIT;
            S_FWAIT: if (p_done) begin
               cbw[idx] <= p_rdata;
               if (idx == IDX_W'(3)) len_q <= p_rdata;
               if (idx == IDX_W'(CB_WORDS - 1)) begin
                  st <= S_SETUP;
               end else begin
                  idx <= idx + 1'b1;
                  st  <= S_FGO;
               end
            end
            S_SETUP: begin
               src_a      <= cbw[1];
               dst_a      <= cbw[2];
               rows_left  <= dec_rows;
               words_left <= dec_words;
               bytes_left <= dec_bytes;
               if (dec_rows == '0)       st <= S_DONE;
               else if (dec_words == '0) st <= S_ROW;
               else                      st <= S_BEGIN;
            end
            S_BEGIN: begin
               if (flags.src_skip) begin
                  beat_data <= '0;
                  st        <= flags.dst_skip ? S_BEAT : S_WGO;
               end else begin
                  st <= S_RGO;
               end
            end
            S_RGO: st <= S_RWAIT;
            S_RWAIT: if (p_done) begin
               beat_data <= p_rdata;
               st        <= flags.dst_skip ? S_BEAT : S_WGO;
            end
            S_WGO: st <= S_WWAIT;
            S_WWAIT: if (p_done) st <= S_BEAT;
            S_BEAT: begin
               if (flags.src_inc) src_a <= src_a + AW'(4);
               if (flags.dst_inc) dst_a <= dst_a + AW'(4);
               bytes_left <= bytes_nx;
               len_q      <= flags.two_d ?
                             {{(DW-ROW_W-XB_W){1'b0}}, rows_left, bytes_nx[XB_W-1:0]} :
                             bytes_nx;
               words_left <= words_left - 1'b1;
               st         <= (words_left == WCNT_W'(1)) ? S_ROW : S_BEGIN;
            end
            S_ROW: begin
               if (rows_left <= ROW_W'(1)) begin
                  st <= S_DONE;
               end else begin
                  rows_left  <= rows_left - 1'b1;
                  src_a      <= src_a + src_step;
                  dst_a      <= dst_a + dst_step;
                  words_left <= dec_words;
                  bytes_left <= dec_bytes;
                  st         <= (dec_words == '0) ? S_ROW : S_BEGIN;
               end
            end
            S_DONE: begin
               end_q <= 1'b1;
               if (flags.irq_en) int_q <= 1'b1;
               cb_ptr <= cbw[5];
               st     <= S_CHK;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign active_o = active_q;
   assign paused_o = paused_q;
   assign end_o    = end_q;
   assign irq_o    = int_q;
   assign len_o    = len_q;
endmodule

// File: rtl/dma_chain_engine_chk.sv
`timescale 1ns/1ps
module dma_chain_engine_chk #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req_o,
   input logic          mem_we_o,
   input logic [AW-1:0] mem_addr_o,
   input logic [DW-1:0] mem_wdata_o,
   input logic          mem_ready_i,
   input logic          mem_rvalid_i,
   input logic          active_o,
   input logic          paused_o,
   input logic          end_o,
   input logic          irq_o
);
   logic rd_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   rd_pend <= 1'b0;
      else if (mem_req_o && mem_ready_i && !mem_we_o) rd_pend <= 1'b1;
      else if (mem_rvalid_i)                        rd_pend <= 1'b0;
   end

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                       $stable(mem_we_o) && $stable(mem_wdata_o)));
   // R11
   single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pend |-> !mem_req_o);
   // R10
   act_pause_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(active_o && paused_o));
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active_o |-> !mem_req_o);
   // R9
   irq_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> end_o);
endmodule

bind dma_chain_engine dma_chain_engine_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
   .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i),
   .mem_rvalid_i(mem_rvalid_i), .active_o(active_o), .paused_o(paused_o),
   .end_o(end_o), .irq_o(irq_o)
);

// File: tb/dma_chain_engine_bench.sv
`timescale 1ns/1ps
module dma_chain_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        chan_en = 1'b1;
   logic [31:0] cb_addr = '0;
   logic        mem_req, mem_we, mem_ready = 1'b0, mem_rvalid = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic        active, paused, end_f, irq;
   logic [31:0] len;

   int nchk = 0;
   int nerr = 0;
   int cyc  = 0;

   logic [31:0] mem [0:1023];

   bit          exp_we   [$];
   logic [31:0] exp_addr [$];
   logic [31:0] exp_data [$];
   string       exp_tag  [$];

   logic        rv_pend = 1'b0;
   logic [31:0] rv_addr = '0;
   logic [7:0]  lfsr = 8'hA7;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dma_chain_engine u_dma_chain_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start), .chan_en_i(chan_en),
      .cb_addr_i(cb_addr), .mem_req_o(mem_req), .mem_we_o(mem_we),
      .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
      .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .active_o(active),
      .paused_o(paused), .end_o(end_f), .irq_o(irq), .len_o(len)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem[a[11:2]];
   endfunction

   task automatic push(input bit we, input logic [31:0] a, input logic [31:0] d,
                       input string tag);
      exp_we.push_back(we);
      exp_addr.push_back(a);
      exp_data.push_back(d);
      exp_tag.push_back(tag);
   endtask

   // Expected transactions of one control block, built from the requirements.
   task automatic push_cb(input logic [31:0] p, output logic [31:0] nxt);
      logic [31:0] info, s, d, ln, sd, dat;
      int rows, bytes, words;
      int sstep, dstep;
      string tg;
      for (int k = 0; k < 6; k++) push(1'b0, p + 32'(4*k), '0, "R2");
      info = rd(p); s = rd(p + 4); d = rd(p + 8); ln = rd(p + 12); sd = rd(p + 16);
      nxt  = rd(p + 20);
      if (info[1]) begin
         rows = int'(ln[29:16]); bytes = int'(ln[15:0]);
         sstep = int'($signed(sd[15:0])); dstep = int'($signed(sd[31:16]));
         tg = "R6";
      end else begin
         rows = 1; bytes = int'(ln); sstep = 0; dstep = 0; tg = "R3";
      end
      words = (bytes + 3) / 4;
      for (int r = 0; r < rows; r++) begin
         for (int w = 0; w < words; w++) begin
            if (!info[11]) push(1'b0, s, '0, tg);
            dat = info[11] ? 32'h0 : rd(s);
            if (!info[7]) push(1'b1, d, dat, info[11] ? "R4" : tg);
            if (info[8]) s = s + 32'd4;
            if (info[4]) d = d + 32'd4;
         end
         if (r != rows - 1) begin
            s = s + 32'(sstep);
            d = d + 32'(dstep);
         end
      end
   endtask

   task automatic expect_chain(input logic [31:0] p, input int max_blocks);
      logic [31:0] cur, nxt;
      int n;
      cur = p; n = 0;
      while (cur != 0 && n < max_blocks) begin
         push_cb(cur, nxt);
         cur = nxt;
         n++;
      end
   endtask

   task automatic write_cb(input logic [31:0] p, input logic [31:0] info,
                           input logic [31:0] s, input logic [31:0] d,
                           input logic [31:0] ln, input logic [31:0] sd,
                           input logic [31:0] nxt);
      mem[p[11:2]]     = info;
      mem[p[11:2] + 1] = s;
      mem[p[11:2] + 2] = d;
      mem[p[11:2] + 3] = ln;
      mem[p[11:2] + 4] = sd;
      mem[p[11:2] + 5] = nxt;
   endtask

   task automatic pulse_start(input logic [31:0] a);
      @(negedge clk);
      cb_addr = a;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
   endtask

   task automatic wait_idle();
      while (active) @(negedge clk);
   endtask

   task automatic run_cb(input logic [31:0] a);
      pulse_start(a);
      wait_idle();
   endtask

   task automatic drained(input string tag);
      chk(exp_addr.size() == 0, tag, "expected transactions left over",
          32'(exp_addr.size()), 32'd0);
      exp_we.delete(); exp_addr.delete(); exp_data.delete(); exp_tag.delete();
   endtask

   // Memory model and scoreboard monitor; drives memory inputs on the falling edge.
   always @(negedge clk) begin
      bit rdy;
      string tg;
      if (!rst_n) begin
         mem_ready  = 1'b0;
         mem_rvalid = 1'b0;
         rv_pend    = 1'b0;
      end else begin
         if (rv_pend) begin
            mem_rvalid = 1'b1;
            mem_rdata  = rd(rv_addr);
            rv_pend    = 1'b0;
         end else begin
            mem_rvalid = 1'b0;
         end
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         rdy  = lfsr[0] | lfsr[2];
         mem_ready = rdy;
         if (mem_req && rdy) begin
            if (exp_addr.size() == 0) begin
               chk(1'b0, "R10", "unexpected request at address", mem_addr, 32'h0);
            end else begin
               tg = exp_tag.pop_front();
               chk(mem_we == exp_we.pop_front(), tg, "request direction",
                   32'(mem_we), 32'(!mem_we));
               chk(mem_addr == exp_addr[0], tg, "request address", mem_addr, exp_addr[0]);
               void'(exp_addr.pop_front());
               if (mem_we)
                  chk(mem_wdata == exp_data[0], tg, "write data", mem_wdata, exp_data[0]);
               void'(exp_data.pop_front());
            end
            if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
            else begin
               rv_pend = 1'b1;
               rv_addr = mem_addr;
            end
         end
      end
   end

   initial begin
      wait (cyc >= 150000);
      chk(1'b0, "R10", "watchdog, channel still active", 32'(active), 32'd0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 32'hA500_0000 | 32'(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(!active && !paused && !end_f && !irq && !mem_req, "R1", "reset outputs",
          {27'b0, active, paused, end_f, irq, mem_req}, 32'h0);

      // R3 flat, both increment, interrupt on; R9 flags; R8 length
      write_cb(32'h040, 32'h111, 32'h200, 32'h600, 32'd16, 32'h0, 32'h0);
      expect_chain(32'h040, 8);
      run_cb(32'h040);
      drained("R3");
      chk(end_f && irq, "R9", "end/irq after block with irq enabled",
          {30'b0, end_f, irq}, 32'h3);
      chk(len == 0, "R8", "flat remaining length", len, 32'h0);
      chk(!active && paused, "R10", "active/paused after null next",
          {30'b0, active, paused}, 32'h1);

      // R3 rounding (6 bytes -> 2 beats), fixed source; R9 start clears irq
      write_cb(32'h060, 32'h010, 32'h210, 32'h640, 32'd6, 32'h0, 32'h0);
      expect_chain(32'h060, 8);
      run_cb(32'h060);
      drained("R3");
      chk(!irq && end_f, "R9", "irq cleared by start, end set",
          {30'b0, end_f, irq}, 32'h2);

      // R4 source switched off
      write_cb(32'h080, 32'h910, 32'h220, 32'h660, 32'd8, 32'h0, 32'h0);
      expect_chain(32'h080, 8);
      run_cb(32'h080);
      drained("R4");

      // R5 destination switched off
      write_cb(32'h0A0, 32'h190, 32'h230, 32'h680, 32'd12, 32'h0, 32'h0);
      expect_chain(32'h0A0, 8);
      run_cb(32'h0A0);
      drained("R5");

      // R6 row mode: 3 rows of 8 bytes, src stride -4, dst stride +8
      write_cb(32'h0C0, 32'h113, 32'h240, 32'h700, 32'h0003_0008, 32'h0008_FFFC, 32'h0);
      expect_chain(32'h0C0, 8);
      run_cb(32'h0C0);
      drained("R6");
      chk(len == 32'h0001_0000, "R8", "row-mode remaining length", len, 32'h0001_0000);

      // R7 row mode with zero rows
      write_cb(32'h0E0, 32'h003, 32'h250, 32'h780, 32'h0000_0010, 32'h0, 32'h0);
      expect_chain(32'h0E0, 8);
      run_cb(32'h0E0);
      drained("R7");
      chk(end_f && irq, "R7", "zero-row block completes", {30'b0, end_f, irq}, 32'h3);

      // R10 chain of two blocks
      write_cb(32'h100, 32'h110, 32'h260, 32'h7C0, 32'd8, 32'h0, 32'h120);
      write_cb(32'h120, 32'h111, 32'h270, 32'h7E0, 32'd4, 32'h0, 32'h0);
      expect_chain(32'h100, 8);
      run_cb(32'h100);
      drained("R10");
      chk(irq, "R10", "second block raised irq", 32'(irq), 32'h1);

      // R10 enable dropped during first block ends the walk there
      write_cb(32'h140, 32'h110, 32'h280, 32'h800, 32'd16, 32'h0, 32'h160);
      write_cb(32'h160, 32'h111, 32'h290, 32'h840, 32'd4, 32'h0, 32'h0);
      expect_chain(32'h140, 1);
      pulse_start(32'h140);
      repeat (3) @(negedge clk);
      chan_en = 1'b0;
      wait_idle();
      chan_en = 1'b1;
      drained("R10");
      chk(end_f && !irq && paused, "R10", "stop on enable: end/irq/paused",
          {29'b0, end_f, irq, paused}, 32'h5);

      // R12 start while active is ignored
      write_cb(32'h180, 32'h110, 32'h2A0, 32'h880, 32'd16, 32'h0, 32'h0);
      expect_chain(32'h180, 8);
      pulse_start(32'h180);
      repeat (5) @(negedge clk);
      pulse_start(32'h040);
      wait_idle();
      drained("R12");

      // R10 null start address: no traffic, paused at once
      run_cb(32'h0);
      drained("R10");
      chk(!active && paused && !end_f, "R10", "null start address",
          {29'b0, active, paused, end_f}, 32'h2);

      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule